// File: doc/BRIEF.md
# Store Permission Prefetch Issuer

This block sits next to a store queue. In the cycle that a store's data is written into its queue entry, it decides whether to send the data cache an early hint asking for write permission on the store's line, long before the store commits. A hint carries no data and expects no answer. A refused hint is simply dropped.

A hint needs every eligibility condition to hold, plus a free cache port in the current cycle. Ordinary load and store traffic reports how many of the configured cache ports it has already taken this cycle, and each hint takes one more. A store that crosses a line boundary arrives already split into a low and a high address and may produce two hints on two request lanes, both tagged with the same queue index. The high hint is attempted only when the low one was taken and a second port is free. Two saturating counters record how many hints were taken and how many were refused.

Top module: `store_perm_hint_issuer`

## Requirements
- R1: Lane 0 (`h0_valid`) is high in a cycle exactly when all of these hold: `wr_valid` is high, `pend_pkt` is low, `wr_size` is nonzero, and `wr_is_pf`, `wr_uncached` and `wr_mmio` are all low. The address and port conditions of R2 and R3 must also hold.
- R2: The address condition holds when `MEM_BASE <= wr_addr_lo < MEM_LIMIT`. The lower bound is inclusive and the upper bound is exclusive.
- R3: The number of free ports is `CACHE_PORTS - ports_used`, or zero when `ports_used >= CACHE_PORTS`. Lane 0 needs at least one free port.
- R4: Lane 1 (`h1_valid`) is high exactly when lane 0 is valid, `wr_split` is high, `h0_ready` is high and at least two ports are free. Lane 1 then carries `wr_addr_hi` and `wr_idx`.
- R5: While lane 0 is valid, it carries `wr_addr_lo` and `wr_idx`, and its split flag equals `wr_split`.
- R6: A refused hint is never retried. Neither lane is valid in a cycle with `wr_valid` low, whatever happened in earlier cycles.
- R7: One cycle after a handshake, `acc_count` has risen by the number of lanes with valid and ready both high, and `rej_count` has risen by the number of lanes with valid high and ready low. A split store can add one to each counter.
- R8: Both counters saturate at all ones and never wrap.
- R9: During and right after reset, both counters read zero and, with `wr_valid` low, neither lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store data is written into the queue this cycle |
| wr_idx | input | IDX_W | Store queue index of the store |
| wr_addr_lo | input | ADDR_W | Physical address of the store, or of its low part if split |
| wr_addr_hi | input | ADDR_W | Physical address of the high part of a split store |
| wr_size | input | SIZE_W | Store size in bytes |
| wr_split | input | 1 | Store crosses a line and was split in two |
| wr_is_pf | input | 1 | Instruction is a data prefetch |
| wr_uncached | input | 1 | Access is uncacheable |
| wr_mmio | input | 1 | Access is memory-mapped register space |
| pend_pkt | input | 1 | An earlier packet is still waiting to be sent |
| ports_used | input | PORT_W | Cache ports already taken this cycle by other traffic |
| h0_valid | output | 1 | Lane 0 hint request |
| h0_ready | input | 1 | Cache accepts lane 0 |
| h0_addr | output | ADDR_W | Lane 0 address |
| h0_idx | output | IDX_W | Lane 0 queue index |
| h0_split | output | 1 | Lane 0 is the low half of a split store |
| h1_valid | output | 1 | Lane 1 (high half) hint request |
| h1_ready | input | 1 | Cache accepts lane 1 |
| h1_addr | output | ADDR_W | Lane 1 address |
| h1_idx | output | IDX_W | Lane 1 queue index |
| acc_count | output | CNT_W | Saturating count of accepted hints |
| rej_count | output | CNT_W | Saturating count of refused hints |

## Verification
The assertions assume that the cache's ready inputs do not depend on the valid outputs in the same cycle. They also assume that `ports_used` stays stable between clock edges. The bench keeps to this by driving all inputs, readies included, once just after each falling edge and holding them until the next one. It then sweeps every combination of the qualifier bits, the port counts 0 to 3 against two configured ports, both readies, and four addresses placed on and around each bound of the range. Narrow counters are used so that saturation is reached within the sweep.

// File: rtl/sph_pkg.sv
package sph_pkg;

    // Outcome of one request lane in one cycle
    typedef enum logic [1:0] {
        LANE_IDLE    = 2'd0,
        LANE_TAKEN   = 2'd1,
        LANE_REFUSED = 2'd2
    } lane_res_e;

endpackage

// File: rtl/sph_gate.sv
module sph_gate #(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 4,
    parameter int CACHE_PORTS = 2,
    parameter int PORT_W      = $clog2(CACHE_PORTS + 1),
    parameter logic [ADDR_W-1:0] MEM_BASE  = ADDR_W'('h1000),
    parameter logic [ADDR_W-1:0] MEM_LIMIT = ADDR_W'('h8000_0000)
) (
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr_lo,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_is_pf,
    input  logic              wr_uncached,
    input  logic              wr_mmio,
    input  logic              pend_pkt,
    input  logic [PORT_W-1:0] ports_used,
    output logic              elig,
    output logic              two_free
);
    localparam logic [PORT_W-1:0] NPORTS = PORT_W'(CACHE_PORTS);
    localparam logic [PORT_W-1:0] ONE    = PORT_W'(1);

    logic [PORT_W-1:0] free_ports;
    logic              in_range;
    logic              qual_ok;

    always_comb begin
        free_ports = (ports_used >= NPORTS) ? '0 : (NPORTS - ports_used);
        in_range   = (wr_addr_lo >= MEM_BASE) && (wr_addr_lo < MEM_LIMIT);
        qual_ok    = wr_valid && !pend_pkt && (wr_size != '0)
                     && !wr_is_pf && !wr_uncached && !wr_mmio;
        elig       = qual_ok && in_range && (free_ports != '0);
        two_free   = free_ports > ONE;
    end
endmodule

// File: rtl/sph_lanes.sv
module sph_lanes
    import sph_pkg::*;
(
    input  logic      elig,
    input  logic      split,
    input  logic      two_free,
    input  logic      ready0,
    input  logic      ready1,
    output logic      valid0,
    output logic      valid1,
    output lane_res_e res0,
    output lane_res_e res1
);
    always_comb begin
        valid0 = elig;
        valid1 = elig && split && ready0 && two_free;
        res0   = !valid0 ? LANE_IDLE : (ready0 ? LANE_TAKEN : LANE_REFUSED);
        res1   = !valid1 ? LANE_IDLE : (ready1 ? LANE_TAKEN : LANE_REFUSED);
    end
endmodule

// File: rtl/sph_sat_ctr.sv
module sph_sat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.cnt} + {{(W-1){1'b0}}, inc};
        st_d.cnt = sum[W] ? MAXV : sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/store_perm_hint_issuer.sv
module store_perm_hint_issuer
    import sph_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 5,
    parameter int SIZE_W      = 4,
    parameter int CACHE_PORTS = 2,
    parameter int PORT_W      = $clog2(CACHE_PORTS + 1),
    parameter int CNT_W       = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE  = ADDR_W'('h1000),
    parameter logic [ADDR_W-1:0] MEM_LIMIT = ADDR_W'('h8000_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr_lo,
    input  logic [ADDR_W-1:0] wr_addr_hi,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              wr_split,
    input  logic              wr_is_pf,
    input  logic              wr_uncached,
    input  logic              wr_mmio,
    input  logic              pend_pkt,
    input  logic [PORT_W-1:0] ports_used,
    output logic              h0_valid,
    input  logic              h0_ready,
    output logic [ADDR_W-1:0] h0_addr,
    output logic [IDX_W-1:0]  h0_idx,
    output logic              h0_split,
    output logic              h1_valid,
    input  logic              h1_ready,
    output logic [ADDR_W-1:0] h1_addr,
    output logic [IDX_W-1:0]  h1_idx,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CNT_W-1:0]  rej_count
);
    localparam int NCTR = 2;

    logic      elig, two_free;
    lane_res_e res0, res1;
    logic [1:0] inc_d [NCTR];
    logic [CNT_W-1:0] cnt_q [NCTR];

    sph_gate #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CACHE_PORTS(CACHE_PORTS),
        .PORT_W(PORT_W), .MEM_BASE(MEM_BASE), .MEM_LIMIT(MEM_LIMIT)
    ) u_gate (
        .wr_valid(wr_valid), .wr_addr_lo(wr_addr_lo), .wr_size(wr_size),
        .wr_is_pf(wr_is_pf), .wr_uncached(wr_uncached), .wr_mmio(wr_mmio),
        .pend_pkt(pend_pkt), .ports_used(ports_used),
        .elig(elig), .two_free(two_free)
    );

    sph_lanes u_lanes (
        .elig(elig), .split(wr_split), .two_free(two_free),
        .ready0(h0_ready), .ready1(h1_ready),
        .valid0(h0_valid), .valid1(h1_valid),
        .res0(res0), .res1(res1)
    );

    // counter 0 counts taken hints, counter 1 refused hints
    always_comb begin
        inc_d[0] = {1'b0, res0 == LANE_TAKEN}   + {1'b0, res1 == LANE_TAKEN};
        inc_d[1] = {1'b0, res0 == LANE_REFUSED} + {1'b0, res1 == LANE_REFUSED};
    end

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        sph_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .inc(inc_d[g]), .count(cnt_q[g])
        );
    end

    assign acc_count = cnt_q[0];
    assign rej_count = cnt_q[1];
    assign h0_addr   = wr_addr_lo;
    assign h0_idx    = wr_idx;
    assign h0_split  = wr_split;
    assign h1_addr   = wr_addr_hi;
    assign h1_idx    = wr_idx;
endmodule

// File: rtl/sph_chk.sv
module sph_chk #(
    parameter int CACHE_PORTS = 2,
    parameter int PORT_W      = 2,
    parameter int CNT_W       = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_split,
    input logic [PORT_W-1:0] ports_used,
    input logic              h0_valid,
    input logic              h0_ready,
    input logic              h0_split,
    input logic              h1_valid,
    input logic              h1_ready,
    input logic [CNT_W-1:0]  acc_count,
    input logic [CNT_W-1:0]  rej_count
);
    localparam logic [PORT_W-1:0] NPORTS = PORT_W'(CACHE_PORTS);
    localparam logic [CNT_W-1:0]  MAXV   = '1;
    localparam logic [CNT_W-1:0]  TWO    = CNT_W'(2);

    // R6
    no_write_no_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (!h0_valid && !h1_valid));

    // R4
    high_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h1_valid |-> (h0_valid && h0_ready && h0_split && wr_split));

    // R3
    no_port_no_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ports_used >= NPORTS) |-> !h0_valid);

    // R7
    acc_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h0_valid && h0_ready && acc_count != MAXV) |=> (acc_count != $past(acc_count)));

    // R7
    rej_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h0_valid && !h0_ready && rej_count != MAXV) |=> (rej_count != $past(rej_count)));

    // R8
    acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc_count >= $past(acc_count) && (acc_count - $past(acc_count)) <= TWO));

    // R8
    rej_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rej_count >= $past(rej_count) && (rej_count - $past(rej_count)) <= TWO));

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!h0_valid && !h1_valid) |=> ($stable(acc_count) && $stable(rej_count)));

    // R4
    lane1_ready_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h1_valid && h1_ready && acc_count < MAXV - TWO && h0_ready)
        |=> (acc_count == $past(acc_count) + TWO));
endmodule

bind store_perm_hint_issuer sph_chk #(
    .CACHE_PORTS(CACHE_PORTS), .PORT_W(PORT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_split(wr_split),
    .ports_used(ports_used), .h0_valid(h0_valid), .h0_ready(h0_ready),
    .h0_split(h0_split), .h1_valid(h1_valid), .h1_ready(h1_ready),
    .acc_count(acc_count), .rej_count(rej_count)
);

// File: tb/store_perm_hint_issuer_tb.sv
module store_perm_hint_issuer_tb;
    localparam int AW = 16;
    localparam int IW = 5;
    localparam int SW = 4;
    localparam int NP = 2;
    localparam int PW = 2;
    localparam int CW = 4;
    localparam logic [AW-1:0] BASE  = 16'h1000;
    localparam logic [AW-1:0] LIMIT = 16'h8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, wr_split = 0, wr_is_pf = 0, wr_uncached = 0, wr_mmio = 0, pend_pkt = 0;
    logic [IW-1:0] wr_idx = '0;
    logic [AW-1:0] wr_addr_lo = '0, wr_addr_hi = '0;
    logic [SW-1:0] wr_size = '0;
    logic [PW-1:0] ports_used = '0;
    logic h0_ready = 0, h1_ready = 0;
    logic h0_valid, h0_split, h1_valid;
    logic [AW-1:0] h0_addr, h1_addr;
    logic [IW-1:0] h0_idx, h1_idx;
    logic [CW-1:0] acc_count, rej_count;

    int checks = 0;
    int fails = 0;
    int exp_acc = 0;
    int exp_rej = 0;
    bit done = 0;

    always #10 clk = ~clk;

    store_perm_hint_issuer #(
        .ADDR_W(AW), .IDX_W(IW), .SIZE_W(SW), .CACHE_PORTS(NP), .PORT_W(PW),
        .CNT_W(CW), .MEM_BASE(BASE), .MEM_LIMIT(LIMIT)
    ) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        wr_valid = 0;
        repeat (2) @(negedge clk);
        // R9 counters zero during reset
        chk("R9", int'(acc_count), 0);
        chk("R9", int'(rej_count), 0);
        rst_n = 1;
        exp_acc = 0;
        exp_rej = 0;
    endtask

    function automatic int sat(input int v);
        return (v > 15) ? 15 : v;
    endfunction

    logic [AW-1:0] addr_pick [4];

    initial begin
        addr_pick[0] = 16'h0FFF;
        addr_pick[1] = 16'h1000;
        addr_pick[2] = 16'h7FFF;
        addr_pick[3] = 16'h8000;
        do_reset();
        @(negedge clk);
        chk("R9", int'(h0_valid), 0);
        chk("R9", int'(acc_count), 0);

        for (int n = 0; n < 16384; n++) begin
            int used, e0, e1, fr, nacc, nrej;
            bit inr;
            if (n == 8192) do_reset();
            @(negedge clk);
            wr_valid    = n[0];
            pend_pkt    = n[1];
            wr_size     = n[2] ? 4'd4 : 4'd0;
            wr_is_pf    = n[3];
            wr_uncached = n[4];
            wr_mmio     = n[5];
            wr_split    = n[6];
            h0_ready    = n[7];
            h1_ready    = n[8];
            ports_used  = PW'(n[10:9]);
            wr_addr_lo  = addr_pick[n[12:11]];
            wr_addr_hi  = wr_addr_lo + 16'h0040;
            wr_idx      = IW'(n * 7);
            used = int'(ports_used);
            fr   = (used >= NP) ? 0 : NP - used;
            inr  = (wr_addr_lo >= BASE) && (wr_addr_lo < LIMIT);
            e0 = (wr_valid && !pend_pkt && wr_size != 0 && !wr_is_pf && !wr_uncached
                  && !wr_mmio && inr && fr >= 1) ? 1 : 0;
            e1 = (e0 == 1 && wr_split && h0_ready && fr >= 2) ? 1 : 0;
            #2;
            if (n[12:11] == 2'b00 || n[12:11] == 2'b11)
                chk("R2 range", int'(h0_valid), e0);
            else if (used >= NP)
                chk("R3 budget", int'(h0_valid), e0);
            else
                chk("R1 qualify", int'(h0_valid), e0);
            chk("R4 high lane", int'(h1_valid), e1);
            if (!wr_valid) chk("R6 idle", int'(h0_valid | h1_valid), 0);
            if (e0 == 1) begin
                chk("R5 addr", int'(h0_addr), int'(wr_addr_lo));
                chk("R5 idx", int'(h0_idx), int'(wr_idx));
                chk("R5 split", int'(h0_split), int'(wr_split));
            end
            if (e1 == 1) begin
                chk("R4 addr", int'(h1_addr), int'(wr_addr_hi));
                chk("R4 idx", int'(h1_idx), int'(wr_idx));
            end
            nacc = (e0 & int'(h0_ready)) + (e1 & int'(h1_ready));
            nrej = (e0 & int'(!h0_ready)) + (e1 & int'(!h1_ready));
            exp_acc = sat(exp_acc + nacc);
            exp_rej = sat(exp_rej + nrej);
            @(posedge clk);
            #2;
            if (exp_acc == 15) chk("R8 acc sat", int'(acc_count), exp_acc);
            else               chk("R7 acc", int'(acc_count), exp_acc);
            if (exp_rej == 15) chk("R8 rej sat", int'(rej_count), exp_rej);
            else               chk("R7 rej", int'(rej_count), exp_rej);
        end

        // R6 directed: a refused hint followed by idle cycles is not resent
        do_reset();
        @(negedge clk);
        wr_valid = 1; pend_pkt = 0; wr_size = 4'd8; wr_is_pf = 0; wr_uncached = 0;
        wr_mmio = 0; wr_split = 0; ports_used = '0; wr_addr_lo = 16'h2000;
        h0_ready = 0; h1_ready = 0;
        #2;
        chk("R6 offered", int'(h0_valid), 1);
        @(negedge clk);
        wr_valid = 0; h0_ready = 1;
        #2;
        chk("R6 no retry", int'(h0_valid), 0);
        chk("R7 refused once", int'(rej_count), 1);
        @(negedge clk);
        #2;
        chk("R6 no retry later", int'(h0_valid), 0);
        chk("R7 nothing taken", int'(acc_count), 0);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule